// File: doc/BRIEF.md
# Conversion Restart and Calibration Sequencer

This block controls when a decimating converter's output may be trusted after its processing has been disturbed. It accepts two asynchronous restart requests, a plain restart and a full restart, and a calibration request that is sampled on the master clock. A restart request takes effect at once: the decimation filter counter is held clear and the block reports itself busy, without waiting for a clock edge. The request is released on the first rising master clock edge that samples both restart inputs low. A full restart also clears the stored offset and gain correction values. A plain restart leaves them untouched.

After a release, a settle counter keeps the data-valid flag low for a fixed number of master clocks, which is 128 output words. In parallel read mode, busy (which holds off the read port's data-ready) stays high for one more output word. A calibration request first waits one output word. It then runs a train of alternating long and short measurement segments: five segments in unipolar mode and seven in bipolar mode. Each segment opens with a one-cycle strobe carrying the segment index. One more output word after the last segment, the result is valid again. A separate guard drops data-valid for the settle time whenever the input overrange flag is seen. The long, short and word lengths are parameters, so a bench can shrink them.

Top module: `conv_sequencer`

## Requirements
- R1: While `sync_req` or `reset_req` is high, `filt_clr` and `busy` are high and `data_valid` is low, with no clock edge needed.
- R2: `filt_clr` stays high through every rising edge that samples a restart input high. It falls at the first rising edge that samples both restart inputs low (the release edge).
- R3: After the release edge, `data_valid` rises after LONG_LEN edges. `busy` falls after LONG_LEN+CONV_LEN edges when `par_mode`=1, and together with `data_valid` after LONG_LEN edges when `par_mode`=0.
- R4: `cal_clr` is high while `reset_req` holds the block and falls at the release edge. A `sync_req` alone never raises it.
- R5: A rising edge that samples `cal_req`=1 (with no restart pending) starts calibration. From that edge, `busy`=1 and `data_valid`=0.
- R6: The first segment strobe (`cal_stb`=1 for one cycle, `cal_seg`=0) appears CONV_LEN edges after the accepting edge. Segments alternate long (even index, LONG_LEN) and short (odd index, SHORT_LEN), each opening with a strobe that carries its index. `bipolar`=0 gives 5 segments and `bipolar`=1 gives 7. The mode is latched at the accepting edge, and later changes of `bipolar` have no effect on the running sequence.
- R7: CONV_LEN edges after the last segment ends, `data_valid` rises and `busy` falls in the same cycle. The total from the accepting edge is 2·CONV_LEN + 3·LONG_LEN + 2·SHORT_LEN (unipolar) or 2·CONV_LEN + 4·LONG_LEN + 3·SHORT_LEN (bipolar).
- R8: An edge that samples `overrange`=1 holds `data_valid` low for the next LONG_LEN edges. It leaves `busy` unchanged.
- R9: A `cal_req` accepted during a running calibration restarts the sequence from its beginning. A `cal_req` sampled while a restart input is high is ignored: no segment strobe follows.
- R10: An edge with `rst`=1 acts as a release edge: `busy`=1, `data_valid`=0, and the settle count of R3 starts from the last such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req | input | 1 | Asynchronous plain restart request, active high |
| reset_req | input | 1 | Asynchronous full restart request, active high; also clears correction values |
| cal_req | input | 1 | Calibration request, sampled on the rising clock edge |
| bipolar | input | 1 | 1 selects bipolar calibration (7 segments), 0 unipolar (5 segments) |
| par_mode | input | 1 | 1 selects parallel read timing (extra output word before busy falls) |
| overrange | input | 1 | Input overrange flag from the modulator path |
| filt_clr | output | 1 | Holds the decimation filter counter at zero |
| cal_clr | output | 1 | Clears the offset and gain correction registers |
| cal_stb | output | 1 | One-cycle strobe at the start of each calibration segment |
| cal_seg | output | 3 | Index of the current calibration segment |
| cal_active | output | 1 | High while calibration segments run |
| data_valid | output | 1 | Output word is a trusted conversion result |
| busy | output | 1 | High from an event until the first valid result; holds off data-ready |

## Verification
The sharpest collision is a calibration request that arrives in the same clock edge as a pending restart hold. Here the restart must win and the calibration must leave no trace. The bench raises `cal_req` while `sync_req` is still high, releases both together, and then requires a plain settle duration with zero segment strobes. A second overlap is a new calibration request that lands in the middle of a running segment train. This is judged by the full-length busy window and by the strobe indices starting again at zero. The bench also checks that an overrange pulse sampled while idle lowers `data_valid` for exactly the settle count, while `busy` stays low throughout.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    localparam int SEG_W = 3;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HOLD,
        ST_SETTLE,
        ST_LEAD,
        ST_SEG,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic             bip;
        logic [SEG_W-1:0] seg;
        logic             stb;
    } cal_ctx_t;

    // index of the final segment: long segments at even indices
    function automatic logic [SEG_W-1:0] last_seg(input logic bip);
        return bip ? SEG_W'(6) : SEG_W'(4);
    endfunction

endpackage

// File: rtl/cseq_evt_capture.sv
module cseq_evt_capture (
    input  logic clk,
    input  logic sync_req,
    input  logic reset_req,
    output logic hold,
    output logic release_now,
    output logic cal_clr
);
    logic hold_q;
    logic clr_q;

    // set at once by either request, cleared by the first edge that sees both low
    always_ff @(posedge clk or posedge sync_req or posedge reset_req) begin
        if (sync_req || reset_req) hold_q <= 1'b1;
        else                       hold_q <= 1'b0;
    end

    // correction-value clear follows only the full restart request
    always_ff @(posedge clk or posedge reset_req) begin
        if (reset_req) clr_q <= 1'b1;
        else           clr_q <= 1'b0;
    end

    assign hold        = hold_q;
    assign release_now = hold_q && !sync_req && !reset_req;
    assign cal_clr     = clr_q;

    // R4: the correction clear never stands without a restart hold
    assert_clr_needs_hold_R4: assert property (@(posedge clk) !hold_q |-> !clr_q);

endmodule

// File: rtl/cseq_ovr_guard.sv
module cseq_ovr_guard #(
    parameter int LONG_LEN = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic overrange,
    output logic ovr_ok
);
    localparam int OW = $clog2(LONG_LEN + 1);

    logic [OW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (overrange)      left_q <= OW'(LONG_LEN);
        else if (left_q != '0)   left_q <= left_q - OW'(1);
    end

    assign ovr_ok = (left_q == '0);

    // R8: a flagged edge is always followed by a blocked cycle
    assert_ovr_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        overrange |=> !ovr_ok);

endmodule

// File: rtl/cseq_core.sv
module cseq_core
    import cseq_pkg::*;
#(
    parameter int LONG_LEN  = 8192,
    parameter int SHORT_LEN = 512,
    parameter int CONV_LEN  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             release_now,
    input  logic             cal_req,
    input  logic             bipolar,
    input  logic             par_mode,
    input  logic             ovr_ok,
    output logic             data_valid,
    output logic             busy,
    output logic             cal_stb,
    output logic [SEG_W-1:0] cal_seg,
    output logic             cal_active
);
    localparam int CW = $clog2(LONG_LEN + CONV_LEN + 1);
    localparam logic [CW-1:0] END_PAR   = CW'(LONG_LEN + CONV_LEN - 1);
    localparam logic [CW-1:0] END_SER   = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] VALID_AT  = CW'(LONG_LEN);
    localparam logic [CW-1:0] WORD_LAST = CW'(CONV_LEN - 1);
    localparam logic [CW-1:0] LONG_LAST = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] SHRT_LAST = CW'(SHORT_LEN - 1);

    seq_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    cal_ctx_t       ctx_q, ctx_d;

    logic [CW-1:0]  seg_last;
    logic [CW-1:0]  settle_last;

    assign seg_last    = ctx_q.seg[0] ? SHRT_LAST : LONG_LAST;
    assign settle_last = par_mode ? END_PAR : END_SER;

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q + CW'(1);
        ctx_d      = ctx_q;
        ctx_d.stb  = 1'b0;
        unique case (state_q)
            ST_RUN, ST_HOLD: cnt_d = '0;
            ST_SETTLE: begin
                if (cnt_q >= settle_last) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_LEAD: begin
                if (cnt_q == WORD_LAST) begin
                    state_d   = ST_SEG;
                    cnt_d     = '0;
                    ctx_d.seg = '0;
                    ctx_d.stb = 1'b1;
                end
            end
            ST_SEG: begin
                if (cnt_q == seg_last) begin
                    cnt_d = '0;
                    if (ctx_q.seg == last_seg(ctx_q.bip)) begin
                        state_d = ST_TAIL;
                    end else begin
                        ctx_d.seg = ctx_q.seg + SEG_W'(1);
                        ctx_d.stb = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (cnt_q == WORD_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase

        // event priority: release, then hold, then calibration request
        if (release_now) begin
            state_d   = ST_SETTLE;
            cnt_d     = '0;
            ctx_d.seg = '0;
            ctx_d.stb = 1'b0;
        end else if (hold) begin
            state_d   = ST_HOLD;
            cnt_d     = '0;
            ctx_d.stb = 1'b0;
        end else if (cal_req) begin
            state_d   = ST_LEAD;
            cnt_d     = '0;
            ctx_d.bip = bipolar;
            ctx_d.seg = '0;
            ctx_d.stb = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
            ctx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ctx_q   <= ctx_d;
        end
    end

    assign data_valid = ovr_ok && !hold &&
                        (state_q == ST_RUN || (state_q == ST_SETTLE && cnt_q >= VALID_AT));
    assign busy       = hold || (state_q != ST_RUN);
    assign cal_stb    = ctx_q.stb;
    assign cal_seg    = ctx_q.seg;
    assign cal_active = (state_q == ST_SEG);

    // R2: the edge after the hold falls finds a fresh settle count
    assert_release_settle_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> (state_q == ST_SETTLE && cnt_q == '0));

    // R5: an accepted calibration request makes the block busy and invalid
    assert_cal_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (cal_req && !hold) |=> (busy && !data_valid));

    // R6: strobes last one cycle and the index stays inside the mode's range
    assert_stb_single_R6: assert property (@(posedge clk) disable iff (rst)
        cal_stb |=> !cal_stb);
    assert_seg_range_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEG) |-> (ctx_q.seg <= last_seg(ctx_q.bip)));

    // R7: when busy ends the result is valid unless the overrange guard blocks it
    assert_valid_at_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (data_valid || !ovr_ok));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import cseq_pkg::*;
#(
    parameter int LONG_LEN  = 8192,
    parameter int SHORT_LEN = 512,
    parameter int CONV_LEN  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_req,
    input  logic             reset_req,
    input  logic             cal_req,
    input  logic             bipolar,
    input  logic             par_mode,
    input  logic             overrange,
    output logic             filt_clr,
    output logic             cal_clr,
    output logic             cal_stb,
    output logic [SEG_W-1:0] cal_seg,
    output logic             cal_active,
    output logic             data_valid,
    output logic             busy
);
    logic hold;
    logic release_now;
    logic ovr_ok;

    cseq_evt_capture u_evt (
        .clk         (clk),
        .sync_req    (sync_req),
        .reset_req   (reset_req),
        .hold        (hold),
        .release_now (release_now),
        .cal_clr     (cal_clr)
    );

    cseq_ovr_guard #(.LONG_LEN(LONG_LEN)) u_ovr (
        .clk       (clk),
        .rst       (rst),
        .overrange (overrange),
        .ovr_ok    (ovr_ok)
    );

    cseq_core #(
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN),
        .CONV_LEN  (CONV_LEN)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .hold        (hold),
        .release_now (release_now),
        .cal_req     (cal_req),
        .bipolar     (bipolar),
        .par_mode    (par_mode),
        .ovr_ok      (ovr_ok),
        .data_valid  (data_valid),
        .busy        (busy),
        .cal_stb     (cal_stb),
        .cal_seg     (cal_seg),
        .cal_active  (cal_active)
    );

    assign filt_clr = hold;

    // R1: a sampled restart request always shows as filter clear and busy
    assert_restart_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (sync_req || reset_req) |-> (filt_clr && busy && !data_valid));

endmodule

// File: tb/tb_conv_sequencer.sv
`timescale 1ns/1ps
module tb_conv_sequencer;
    localparam int L = 32;
    localparam int S = 8;
    localparam int C = 4;
    localparam int LIM = 2000;

    // vector: {kind[1:0] (0 plain restart, 1 full restart, 2 calibration), bipolar, par_mode}
    localparam logic [3:0] VEC [6] = '{4'b0001, 4'b0000, 4'b0101, 4'b1001, 4'b1011, 4'b1010};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_req = 1'b0, reset_req = 1'b0, cal_req = 1'b0;
    logic bipolar = 1'b0, par_mode = 1'b1, overrange = 1'b0;
    logic filt_clr, cal_clr, cal_stb, cal_active, data_valid, busy;
    logic [2:0] cal_seg;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    conv_sequencer #(.LONG_LEN(L), .SHORT_LEN(S), .CONV_LEN(C)) dut (
        .clk(clk), .rst(rst), .sync_req(sync_req), .reset_req(reset_req),
        .cal_req(cal_req), .bipolar(bipolar), .par_mode(par_mode),
        .overrange(overrange), .filt_clr(filt_clr), .cal_clr(cal_clr),
        .cal_stb(cal_stb), .cal_seg(cal_seg), .cal_active(cal_active),
        .data_valid(data_valid), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_busy(input int kind, input logic bip, input logic par);
        if (kind == 2) return 2*C + (bip ? 4*L + 3*S : 3*L + 2*S);
        return par ? L + C : L;
    endfunction

    function automatic int exp_valid(input int kind, input logic bip, input logic par);
        if (kind == 2) return exp_busy(kind, bip, par);
        return L;
    endfunction

    // called at the negedge right after the event edge
    task automatic run_seq(output int kb, output int kv, output int ns, output int ks, output int se);
        int k;
        k = 0; kv = -1; ns = 0; ks = -1; se = 0;
        forever begin
            if (cal_stb) begin
                if (ks < 0) ks = k;
                if (int'(cal_seg) != ns) se++;
                ns++;
            end
            if (data_valid && kv < 0) kv = k;
            if (!busy || k >= LIM) break;
            @(negedge clk);
            k++;
        end
        kb = k;
    endtask

    task automatic restart(input int kind);
        if (kind == 1) reset_req = 1'b1; else sync_req = 1'b1;
        #1;
        chk("R1 filt_clr immediate", int'(filt_clr), 1);
        chk("R1 busy immediate", int'(busy), 1);
        chk("R1 valid low", int'(data_valid), 0);
        chk("R4 cal_clr follows full restart", int'(cal_clr), (kind == 1) ? 1 : 0);
        @(negedge clk);
        chk("R2 filt_clr held", int'(filt_clr), 1);
        sync_req = 1'b0; reset_req = 1'b0;
        @(negedge clk);
        chk("R2 filt_clr released", int'(filt_clr), 0);
        chk("R4 cal_clr released", int'(cal_clr), 0);
    endtask

    task automatic start_cal();
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int kb, kv, ns, ks, se;
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", int'(busy), 1);
        chk("R10 valid low in reset", int'(data_valid), 0);
        chk("R10 no strobe in reset", int'(cal_stb), 0);
        rst = 1'b0;
        run_seq(kb, kv, ns, ks, se);
        chk("R10 settle after reset", kb, L + C);
        chk("R10 valid after reset", kv, L);

        for (int i = 0; i < 6; i++) begin
            int kind;
            kind = int'(VEC[i][3:2]);
            bipolar  = VEC[i][1];
            par_mode = VEC[i][0];
            @(negedge clk);
            if (kind == 2) start_cal(); else restart(kind);
            run_seq(kb, kv, ns, ks, se);
            chk((kind == 2) ? "R7 busy span" : "R3 busy span", kb, exp_busy(kind, VEC[i][1], VEC[i][0]));
            chk((kind == 2) ? "R7 valid span" : "R3 valid span", kv, exp_valid(kind, VEC[i][1], VEC[i][0]));
            chk("R6 strobe count", ns, (kind == 2) ? (VEC[i][1] ? 7 : 5) : 0);
            if (kind == 2) begin
                chk("R6 first strobe", ks, C);
                chk("R6 segment index", se, 0);
            end
            chk("R3 valid at idle", int'(data_valid), 1);
        end

        // R5 / R9: second calibration request mid-sequence restarts it
        bipolar = 1'b0; par_mode = 1'b1;
        @(negedge clk);
        start_cal();
        chk("R5 busy after accept", int'(busy), 1);
        chk("R5 valid low after accept", int'(data_valid), 0);
        repeat (C + 10) @(negedge clk);
        start_cal();
        run_seq(kb, kv, ns, ks, se);
        chk("R9 restarted span", kb, exp_busy(2, 1'b0, 1'b1));
        chk("R9 restarted strobes", ns, 5);
        chk("R9 restarted index", se, 0);

        // R6: mode latched at acceptance
        @(negedge clk);
        bipolar = 1'b0;
        start_cal();
        bipolar = 1'b1;
        run_seq(kb, kv, ns, ks, se);
        chk("R6 mode latched strobes", ns, 5);
        chk("R6 mode latched span", kb, exp_busy(2, 1'b0, 1'b1));

        // R9: calibration request during a restart hold is ignored
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0; sync_req = 1'b0;
        @(negedge clk);
        run_seq(kb, kv, ns, ks, se);
        chk("R9 ignored cal strobes", ns, 0);
        chk("R9 ignored cal span", kb, L + C);

        // R8: overrange while idle
        @(negedge clk);
        overrange = 1'b1;
        @(negedge clk);
        overrange = 1'b0;
        begin
            int k;
            int busy_seen;
            k = 0; busy_seen = 0;
            while (!data_valid && k < LIM) begin
                if (busy) busy_seen++;
                @(negedge clk);
                k++;
            end
            chk("R8 valid low span", k, L);
            chk("R8 busy untouched", busy_seen, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule